// File: doc/BRIEF.md
# Double-Buffered Strobed Input Port

This block is a 16-bit parallel input port. It stores up to two words. An external peripheral drives the data pins and pulses a strobe line. Each rising strobe edge that the block detects stores the pin levels in a two-word buffer. Software reads a stored word as two bytes through a small register bus: first the high byte, then the low byte. Only the low-byte read removes the word from the buffer.

A second handshake line is programmable. It can be a status input whose rising edge sets a sticky flag. It can be an output held low or held high. It can also be an interlocked ready output, which is high only while the buffer can accept another word.

A "data present" flag can raise either an interrupt or a DMA request. A port enable input is driven from the chip's general control logic. While it is low, the handshake line is silent and strobes are ignored.

Both handshake inputs pass through two synchronizer flip-flops, and edges are detected after synchronization. All handshake signals are active high. Register map: address 0 is control, 1 is status, 2 is the data high byte, 3 is the data low byte.

Top module: `dbuf_input_port`

## Requirements
- R1: A rising edge on `strobe_in` stores `pin_data`, sampled on the third rising clock edge after the strobe rises. The buffer holds two words, and words are read back oldest first.
- R2: A strobe that arrives while both words are held is ignored. The stored words and the fill level do not change.
- R3: Reading address 2 returns the high byte of the oldest word and has no side effect. Reading address 3 returns its low byte and removes the word from the buffer.
- R4: Status bit 0 (H3S) follows control bit 0. With control bit 0 clear, H3S is 1 whenever at least one word is held. With control bit 0 set, H3S is 1 only while two words are held.
- R5: With control bit 1 set, H3S raises `dma_req` when `svc_use_dma` is 1, or `irq` when `svc_use_dma` is 0. Both outputs are combinational from the block's state.
- R6: Control bits 5..3 select the handshake-line mode. Values 000 to 011 select status-input mode. In that mode a rising edge on `hs_in` sets status bit 1 (H4S). Writing a 1 to status bit 1 clears H4S. With control bit 2 set, H4S drives `irq`.
- R7: Handshake mode 100 holds `hs_out` at 0. Mode 101 holds `hs_out` at 1. In both modes H4S stays 0.
- R8: Modes 110 and 111 select the interlock. `hs_out` is 1 only while the buffer holds fewer than two words and the synchronized strobe is low. H4S stays 0 in this mode.
- R9: While `port_en` is 0, `hs_out` is 0, H4S is 0 and strobes store nothing.
- R10: The control register at address 0 is reset to 0. All 8 of its bits read back as written. Bits 7..6 are a stored submode field with no effect on the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable from the general control logic |
| svc_use_dma | input | 1 | Routes the data service request to `dma_req` (1) or `irq` (0) |
| strobe_in | input | 1 | Asynchronous data strobe, rising edge active |
| hs_in | input | 1 | Asynchronous handshake line, read in status-input mode |
| pin_data | input | 16 | Parallel input pins; bits 15..8 form the high byte |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; combinational, 0 when no read is active |
| hs_out | output | 1 | Handshake output (held level or interlocked ready) |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
A strobe or handshake rise reaches the buffer and H4S on the third clock edge after it. `hs_out` follows one edge after its inputs settle. Register writes and the pop caused by reading address 3 take effect on the edge that ends the bus cycle. Read data, `irq` and `dma_req` are combinational.

The bench therefore holds each strobe and handshake level for four cycles before it checks anything. It samples read data one nanosecond into the bus cycle. It checks state that depends on a write or a pop only in a later bus cycle, with every sample taken on the falling clock edge.

// File: rtl/dbip_pkg.sv
package dbip_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_HI   = 2'd2,
    REG_LO   = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    HSM_STATUS,
    HSM_LOW,
    HSM_HIGH,
    HSM_LOCK
  } hs_mode_e;

  function automatic hs_mode_e decode_hs(input logic [2:0] f);
    if (!f[2])     return HSM_STATUS;
    else if (f[1]) return HSM_LOCK;
    else if (f[0]) return HSM_HIGH;
    else           return HSM_LOW;
  endfunction

endpackage

// File: rtl/dbip_sync.sv
module dbip_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic lvl_d
);
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;

  assign chain_d = {chain_q[STAGES-1:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign lvl   = chain_q[STAGES-1];
  assign lvl_d = chain_q[STAGES];
endmodule

// File: rtl/dbip_buffer.sv
module dbip_buffer #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] head,
  output logic [1:0]       fill,
  output logic [1:0]       fill_next
);
  logic [WIDTH-1:0] front_q, back_q;
  logic [WIDTH-1:0] front_d, back_d;
  logic             front_en, back_en;
  logic [1:0]       cnt_q, cnt_d;
  logic             take, drop;

  always_comb begin
    take     = capture && (cnt_q != 2'd2);
    drop     = pop && (cnt_q != 2'd0);
    cnt_d    = cnt_q;
    front_d  = front_q;
    back_d   = back_q;
    front_en = 1'b0;
    back_en  = 1'b0;
    if (take && drop) begin
      front_d  = din;
      front_en = 1'b1;
    end else if (drop) begin
      front_d  = back_q;
      front_en = 1'b1;
      cnt_d    = cnt_q - 2'd1;
    end else if (take) begin
      if (cnt_q == 2'd0) begin
        front_d  = din;
        front_en = 1'b1;
      end else begin
        back_d  = din;
        back_en = 1'b1;
      end
      cnt_d = cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      front_q <= '0;
      back_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (front_en) front_q <= front_d;
      if (back_en)  back_q  <= back_d;
    end
  end

  assign head      = front_q;
  assign fill      = cnt_q;
  assign fill_next = cnt_d;
endmodule

// File: rtl/dbip_hs_ctrl.sv
module dbip_hs_ctrl
  import dbip_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_en,
  input  logic [2:0] mode_f,
  input  logic       hs_rise,
  input  logic       strobe_lvl,
  input  logic [1:0] fill_next,
  input  logic       clr_flag,
  output logic       hs_out,
  output logic       hs_flag
);
  hs_mode_e kind;
  logic     out_d, out_q;
  logic     flag_d, flag_q;

  always_comb begin
    kind  = decode_hs(mode_f);
    out_d = port_en && ((kind == HSM_HIGH) ||
            ((kind == HSM_LOCK) && (fill_next != 2'd2) && !strobe_lvl));
    if (!port_en || kind != HSM_STATUS) flag_d = 1'b0;
    else if (hs_rise)                    flag_d = 1'b1;
    else if (clr_flag)                   flag_d = 1'b0;
    else                                 flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      out_q  <= out_d;
      flag_q <= flag_d;
    end
  end

  assign hs_out  = out_q;
  assign hs_flag = flag_q;
endmodule

// File: rtl/dbuf_input_port.sv
module dbuf_input_port
  import dbip_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                port_en,
  input  logic                svc_use_dma,
  input  logic                strobe_in,
  input  logic                hs_in,
  input  logic [2*BYTE_W-1:0] pin_data,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [1:0]          bus_addr,
  input  logic [BYTE_W-1:0]   bus_wdata,
  output logic [BYTE_W-1:0]   bus_rdata,
  output logic                hs_out,
  output logic                irq,
  output logic                dma_req
);
  localparam int WIDTH = 2 * BYTE_W;

  logic              stb_lvl, stb_lvl_d, hs_lvl, hs_lvl_d;
  logic              stb_rise, hs_rise;
  logic              capture, pop, ctrl_we, clr_flag;
  logic [BYTE_W-1:0] ctrl_q, ctrl_d;
  logic [WIDTH-1:0]  head;
  logic [1:0]        fill, fill_next;
  logic              h3s, h4s, svc_pend;

  dbip_sync #(.STAGES(SYNC_STAGES)) u_sync_stb (
    .clk(clk), .rst_n(rst_n), .din(strobe_in), .lvl(stb_lvl), .lvl_d(stb_lvl_d));
  dbip_sync #(.STAGES(SYNC_STAGES)) u_sync_hs (
    .clk(clk), .rst_n(rst_n), .din(hs_in), .lvl(hs_lvl), .lvl_d(hs_lvl_d));

  assign stb_rise = stb_lvl & ~stb_lvl_d;
  assign hs_rise  = hs_lvl & ~hs_lvl_d;
  assign capture  = stb_rise & port_en;
  assign pop      = bus_sel & bus_rd & (bus_addr == REG_LO);
  assign ctrl_we  = bus_sel & bus_wr & (bus_addr == REG_CTRL);
  assign clr_flag = bus_sel & bus_wr & (bus_addr == REG_STAT) & bus_wdata[1];
  assign ctrl_d   = ctrl_we ? bus_wdata : ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  dbip_buffer #(.WIDTH(WIDTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .capture(capture), .pop(pop), .din(pin_data),
    .head(head), .fill(fill), .fill_next(fill_next));

  dbip_hs_ctrl u_hs (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .mode_f(ctrl_q[5:3]),
    .hs_rise(hs_rise), .strobe_lvl(stb_lvl), .fill_next(fill_next),
    .clr_flag(clr_flag), .hs_out(hs_out), .hs_flag(h4s));

  assign h3s      = ctrl_q[0] ? (fill == 2'd2) : (fill != 2'd0);
  assign svc_pend = h3s & ctrl_q[1];
  assign dma_req  = svc_pend & svc_use_dma;
  assign irq      = (svc_pend & ~svc_use_dma) | (h4s & ctrl_q[2]);

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && bus_rd) begin
      case (reg_addr_e'(bus_addr))
        REG_CTRL: bus_rdata = ctrl_q;
        REG_STAT: bus_rdata = {{(BYTE_W-2){1'b0}}, h4s, h3s};
        REG_HI:   bus_rdata = head[WIDTH-1:BYTE_W];
        default:  bus_rdata = head[BYTE_W-1:0];
      endcase
    end
  end
endmodule

// File: rtl/dbip_chk.sv
module dbip_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       port_en,
  input logic [2:0] mode_f,
  input logic [1:0] fill,
  input logic       stb_rise,
  input logic       pop,
  input logic       hs_out,
  input logic       h4s,
  input logic       dma_req,
  input logic       svc_use_dma
);
  assert_fill_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= 2'd2);

  assert_full_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == 2'd2 && stb_rise && !pop) |=> fill == 2'd2);

  assert_pop_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == 2'd2 && pop) |=> fill == 2'd1);

  assert_dma_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> svc_use_dma);

  assert_gp_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && mode_f == 3'b101) |=> hs_out);

  assert_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_f[2] |=> !h4s);

  assert_lock_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_f[2:1] == 2'b11 && fill == 2'd2 && !pop) |=> !hs_out);

  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (!hs_out && !h4s));
endmodule

bind dbuf_input_port dbip_chk u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .mode_f(ctrl_q[5:3]),
  .fill(fill), .stb_rise(stb_rise), .pop(pop), .hs_out(hs_out), .h4s(h4s),
  .dma_req(dma_req), .svc_use_dma(svc_use_dma));

// File: tb/dbuf_input_port_test.sv
`timescale 1ns/1ps
module dbuf_input_port_test;
  logic        clk = 1'b0;
  logic        rst_n, port_en, svc_use_dma, strobe_in, hs_in;
  logic [15:0] pin_data;
  logic        bus_sel, bus_wr, bus_rd;
  logic [1:0]  bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        hs_out, irq, dma_req;
  int          n_tests = 0;
  int          n_fail  = 0;
  logic [7:0]  rv;

  always #2 clk = ~clk;

  dbuf_input_port uut (.*);

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0; bus_rd = 0;
  endtask

  task automatic strobe(input logic [15:0] d);
    @(negedge clk);
    pin_data = d; strobe_in = 1;
    repeat (4) @(negedge clk);
    strobe_in = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic hs_pulse();
    @(negedge clk);
    hs_in = 1;
    repeat (4) @(negedge clk);
    hs_in = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_word(input string tag, input logic [15:0] exp);
    logic [7:0] hi, lo;
    rd_reg(2'd2, hi);
    rd_reg(2'd3, lo);
    chk(tag, {hi, lo}, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; port_en = 0; svc_use_dma = 0; strobe_in = 0; hs_in = 0;
    pin_data = '0; bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R10 reset state and control readback
    rd_reg(2'd0, rv); chk("R10 ctrl reset", rv, 8'h00);
    rd_reg(2'd1, rv); chk("R10 status reset", rv, 8'h00);
    chk("R10 outputs reset", {hs_out, irq, dma_req}, 3'b000);
    foreach (rv[i]) begin
      logic [7:0] pat;
      pat = 8'h01 << i;
      wr_reg(2'd0, pat ^ 8'hC3);
      rd_reg(2'd0, rv); chk("R10 ctrl readback", rv, pat ^ 8'hC3);
    end
    wr_reg(2'd0, 8'h00);

    // R9 strobe ignored while disabled
    strobe(16'hDEAD);
    rd_reg(2'd1, rv); chk("R9 strobe ignored when disabled", rv, 8'h00);
    port_en = 1;

    // R1 R2 R3 R4 fill, overflow and drain over several patterns
    for (int k = 0; k < 4; k++) begin
      logic [15:0] w1, w2;
      w1 = 16'h1234 ^ (16'h1111 * k);
      w2 = ~w1 ^ 16'h00F0;
      strobe(w1);
      rd_reg(2'd1, rv); chk("R4 h3s one word", rv, 8'h01);
      strobe(w2);
      strobe(16'hBEEF);
      rd_reg(2'd2, rv); chk("R3 high read", rv, w1[15:8]);
      rd_reg(2'd2, rv); chk("R3 repeat high read no pop", rv, w1[15:8]);
      rd_reg(2'd3, rv); chk("R1 first word low", rv, w1[7:0]);
      read_word("R2 second word survives overflow", w2);
      rd_reg(2'd1, rv); chk("R2 dropped strobe left empty", rv, 8'h00);
    end

    // R3 out-of-order: low byte first still pops
    strobe(16'h55AA);
    rd_reg(2'd3, rv); chk("R3 low read first", rv, 8'hAA);
    rd_reg(2'd1, rv); chk("R3 low read pops", rv, 8'h00);

    // R4 full-only status variant
    wr_reg(2'd0, 8'h01);
    strobe(16'h0102);
    rd_reg(2'd1, rv); chk("R4 full-only one word", rv, 8'h00);
    strobe(16'h0304);
    rd_reg(2'd1, rv); chk("R4 full-only two words", rv, 8'h01);
    read_word("R1 drain a", 16'h0102);
    read_word("R1 drain b", 16'h0304);

    // R5 service request routing
    wr_reg(2'd0, 8'h02);
    strobe(16'h7777);
    chk("R5 irq route", {irq, dma_req}, 2'b10);
    svc_use_dma = 1; #1;
    chk("R5 dma route", {irq, dma_req}, 2'b01);
    read_word("R5 drain", 16'h7777);
    chk("R5 request clears", {irq, dma_req}, 2'b00);
    svc_use_dma = 0;

    // R6 status input mode, clear by writing one
    wr_reg(2'd0, 8'h04);
    hs_pulse();
    rd_reg(2'd1, rv); chk("R6 h4s set", rv, 8'h02);
    chk("R6 h4 irq", irq, 1'b1);
    wr_reg(2'd1, 8'h01);
    rd_reg(2'd1, rv); chk("R6 write zero keeps h4s", rv, 8'h02);
    wr_reg(2'd1, 8'h02);
    rd_reg(2'd1, rv); chk("R6 write one clears h4s", rv, 8'h00);
    chk("R6 irq drops", irq, 1'b0);

    // R7 R8 R9 sweep of handshake modes and enable
    for (int m = 0; m < 8; m++) begin
      for (int en = 0; en < 2; en++) begin
        logic exp_out, exp_flag;
        port_en = en[0];
        wr_reg(2'd0, 8'(m << 3));
        repeat (2) @(negedge clk);
        exp_out = en[0] && (m >= 5);
        chk($sformatf("R7 R8 R9 hs_out mode %0d en %0d", m, en), hs_out, exp_out);
        hs_pulse();
        exp_flag = en[0] && (m < 4);
        rd_reg(2'd1, rv);
        chk($sformatf("R6 R7 R9 h4s mode %0d en %0d", m, en), rv, {6'b0, exp_flag, 1'b0});
        wr_reg(2'd1, 8'h02);
      end
    end

    // R8 interlocked ready
    port_en = 1;
    wr_reg(2'd0, 8'h30);
    repeat (2) @(negedge clk);
    chk("R8 ready when empty", hs_out, 1'b1);
    @(negedge clk); pin_data = 16'hA1B2; strobe_in = 1;
    repeat (4) @(negedge clk);
    chk("R8 low while strobe high", hs_out, 1'b0);
    strobe_in = 0;
    repeat (4) @(negedge clk);
    chk("R8 ready with one word", hs_out, 1'b1);
    strobe(16'hC3D4);
    chk("R8 low when full", hs_out, 1'b0);
    strobe(16'hFFFF);
    chk("R8 stays low on ignored strobe", hs_out, 1'b0);
    read_word("R8 first word", 16'hA1B2);
    @(negedge clk);
    chk("R8 ready after pop", hs_out, 1'b1);
    read_word("R2 R8 second word", 16'hC3D4);
    rd_reg(2'd1, rv); chk("R2 R8 third strobe dropped", rv, 8'h00);

    // R9 disabling in interlock mode
    port_en = 0;
    repeat (2) @(negedge clk);
    chk("R9 hs_out low when disabled", hs_out, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule